// File: doc/BRIEF.md
# Sub-unit bridge quiesce and reset sequencer

This block brings a clock-gated sub-unit inside an already powered island into and out of service. The sub-unit reaches the interconnect through two asynchronous bridges: one on the master side and one on the slave side. The block owns four things: the sub-unit clock enable, its active-low reset, and the stop-request lines of both bridges. It watches each bridge's acknowledge and reports the end of every operation as a one-cycle `op_done` pulse or a one-cycle `timed_out` pulse.

Three commands exist. Enable releases the unit from reset and opens the master bridge, then the slave bridge. Disable drains the slave bridge, then the master bridge, then gates the clock and asserts reset. Reset-pulse runs a complete disable and then a complete enable. Each bridge wait is bounded by `ACK_LIMIT` cycles. When a wait runs out, the block takes a defined unwind path. A fixed identification word is always visible on `id_word`. With `HAS_BRIDGE = 0` the handshakes are skipped, the stop requests stay high and the acknowledges are ignored.

A command is taken only when `cmd_valid` is high while `busy` is low. A command presented while `busy` is high is dropped and is not queued. The block never stalls the requester, so the command pins carry no ready signal.

Top module: `sdq_seq`

## Requirements
- R1: During and after reset: `unit_clk_en`=0, `unit_rst_n`=0, `mst_stop_req`=1, `slv_stop_req`=1, `busy`=0, and neither result pulse is active.
- R2: Enable (`cmd_op`=2'b01) runs the unit clock with reset asserted for at least `PROP_CYCLES` consecutive cycles. It then stops the clock, raises `unit_rst_n` while the clock is stopped, and restarts the clock.
- R3: After the clock restarts, enable clears `mst_stop_req` and waits for the synchronized `mst_ack` to go low. Only then does it clear `slv_stop_req` and wait for `slv_ack` to go low. It ends with `op_done`.
- R4: Disable (`cmd_op`=2'b10) raises `slv_stop_req` and waits for `slv_ack` high. It then raises `mst_stop_req` and waits for `mst_ack` high. Next it drops `unit_clk_en`, then drops `unit_rst_n` in a later cycle, and ends with `op_done`.
- R5: Every bridge wait gives up after `ACK_LIMIT` cycles and the operation ends with `timed_out`.
- R6: If the master bridge does not stop during disable, both stop requests are cleared (slave re-opened, waited on with the same bound). Clock and reset stay on, and the operation reports `timed_out`.
- R7: If the slave bridge does not open during enable, both stop requests are raised. The block waits (bounded) for `mst_ack` high, gates the clock, then asserts reset, and reports `timed_out`.
- R8: If the master bridge does not open during enable, its stop request is raised again, the clock is gated and reset is asserted. If the slave bridge does not stop during disable, its stop request is cleared again. Both cases report `timed_out`.
- R9: Reset-pulse (`cmd_op`=2'b11) performs disable then enable and gives a single result pulse at the end. A disable failure ends it with `timed_out` and the unit left on.
- R10: With `HAS_BRIDGE`=0 both stop requests stay high, the acknowledges have no effect, and only clock and reset are sequenced.
- R11: `op_done` and `timed_out` are single-cycle pulses and are never high together. `cmd_op`=2'b00 and commands arriving while `busy` is high are ignored.
- R12: `id_word` always reads 32'h62726467.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 01 enable, 10 disable, 11 reset-pulse, 00 none |
| busy | output | 1 | A sequence is in progress |
| op_done | output | 1 | One-cycle success pulse |
| timed_out | output | 1 | One-cycle failure pulse |
| unit_clk_en | output | 1 | Sub-unit clock enable |
| unit_rst_n | output | 1 | Sub-unit active-low reset |
| mst_stop_req | output | 1 | Master-side bridge stop request |
| mst_ack | input | 1 | Master-side bridge acknowledge (asynchronous) |
| slv_stop_req | output | 1 | Slave-side bridge stop request |
| slv_ack | input | 1 | Slave-side bridge acknowledge (asynchronous) |
| id_word | output | 32 | Constant identification value |

## Verification
The hardest situations to reach are the unwind paths, because each needs one particular bridge to stay silent at one particular step while the other bridge still answers. The bench models each bridge as an acknowledge that follows its stop request after a per-bridge programmable delay, or never follows it. A vector table changes those delays between commands, so each failure branch is reached from a known prior state. The unit state left behind, on or off, is then read back at the outputs. A second instance built without bridges shows that the acknowledges are ignored there.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_ENABLE  = 2'b01,
    OP_DISABLE = 2'b10,
    OP_RESET   = 2'b11
  } sdq_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_PROP,
    S_EN_HALT,
    S_EN_REL,
    S_EN_RUN,
    S_EN_MWAIT,
    S_EN_SWAIT,
    S_EN_UNWIND,
    S_EN_FAILGATE,
    S_DIS_SWAIT,
    S_DIS_MWAIT,
    S_DIS_SREOPEN,
    S_DIS_GATE,
    S_DIS_DONE
  } sdq_state_e;

  localparam int unsigned SDQ_MST = 0;
  localparam int unsigned SDQ_SLV = 1;
  localparam int unsigned SDQ_NBR = 2;

  localparam logic [31:0] SDQ_ID_WORD = 32'h6272_6467;

endpackage

// File: rtl/sdq_timer.sv
module sdq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdq_bridge_port.sv
module sdq_bridge_port #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stop,
  input  logic clr_stop,
  input  logic ack_async,
  output logic stop_req,
  output logic settled
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      stop_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ack_async};
      if (set_stop)      stop_q <= 1'b1;
      else if (clr_stop) stop_q <= 1'b0;
    end
  end

  assign stop_req = stop_q;
  // The bridge has reached the requested state once its ack matches the request.
  assign settled  = (sync_q[SYNC_STAGES-1] == stop_q);
endmodule

// File: rtl/sdq_seq.sv
module sdq_seq
  import sdq_pkg::*;
#(
  parameter int unsigned PROP_CYCLES = 32,
  parameter int unsigned ACK_LIMIT   = 50,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_BRIDGE  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  output logic        busy,
  output logic        op_done,
  output logic        timed_out,
  output logic        unit_clk_en,
  output logic        unit_rst_n,
  output logic        mst_stop_req,
  input  logic        mst_ack,
  output logic        slv_stop_req,
  input  logic        slv_ack,
  output logic [31:0] id_word
);
  localparam int unsigned MAXC      = (PROP_CYCLES > ACK_LIMIT) ? PROP_CYCLES : ACK_LIMIT;
  localparam int unsigned CW        = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROP_LOAD = CW'(PROP_CYCLES - 1);
  localparam logic [CW-1:0] WAIT_LOAD = CW'(ACK_LIMIT - 1);

  sdq_state_e          st_q, st_n;
  logic                is_rst_q, is_rst_n;
  logic                clk_q, urst_q, done_q, to_q;
  logic                clk_on, clk_off, rst_rel, rst_set, done_n, to_n;
  logic                ld;
  logic [CW-1:0]       ld_val;
  logic                tmr_zero;
  logic [SDQ_NBR-1:0]  set_v, clr_v, settled_v, stop_v, ack_v;

  assign ack_v = {slv_ack, mst_ack};

  sdq_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(tmr_zero)
  );

  generate
    if (HAS_BRIDGE) begin : g_br
      for (genvar b = 0; b < SDQ_NBR; b++) begin : g_port
        sdq_bridge_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
          .clk(clk), .rst_n(rst_n),
          .set_stop(set_v[b]), .clr_stop(clr_v[b]),
          .ack_async(ack_v[b]),
          .stop_req(stop_v[b]), .settled(settled_v[b])
        );
      end
    end else begin : g_nobr
      assign stop_v    = '1;
      assign settled_v = '0;
    end
  endgenerate

  always_comb begin
    st_n = st_q; is_rst_n = is_rst_q;
    ld = 1'b0; ld_val = '0;
    clk_on = 1'b0; clk_off = 1'b0; rst_rel = 1'b0; rst_set = 1'b0;
    set_v = '0; clr_v = '0; done_n = 1'b0; to_n = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid) begin
        if (cmd_op == OP_ENABLE) begin
          is_rst_n = 1'b0; clk_on = 1'b1; ld = 1'b1; ld_val = PROP_LOAD; st_n = S_EN_PROP;
        end else if (cmd_op == OP_DISABLE || cmd_op == OP_RESET) begin
          is_rst_n = (cmd_op == OP_RESET);
          if (HAS_BRIDGE) begin
            set_v[SDQ_SLV] = 1'b1; ld = 1'b1; ld_val = WAIT_LOAD; st_n = S_DIS_SWAIT;
          end else begin
            clk_off = 1'b1; st_n = S_DIS_GATE;
          end
        end
      end
      S_EN_PROP: if (tmr_zero) begin clk_off = 1'b1; st_n = S_EN_HALT; end
      S_EN_HALT: begin rst_rel = 1'b1; st_n = S_EN_REL; end
      S_EN_REL:  begin clk_on = 1'b1; st_n = S_EN_RUN; end
      S_EN_RUN:
        if (HAS_BRIDGE) begin
          clr_v[SDQ_MST] = 1'b1; ld = 1'b1; ld_val = WAIT_LOAD; st_n = S_EN_MWAIT;
        end else begin
          done_n = 1'b1; st_n = S_IDLE;
        end
      S_EN_MWAIT:
        if (settled_v[SDQ_MST]) begin
          clr_v[SDQ_SLV] = 1'b1; ld = 1'b1; ld_val = WAIT_LOAD; st_n = S_EN_SWAIT;
        end else if (tmr_zero) begin
          set_v[SDQ_MST] = 1'b1; clk_off = 1'b1; st_n = S_EN_FAILGATE;
        end
      S_EN_SWAIT:
        if (settled_v[SDQ_SLV]) begin
          done_n = 1'b1; st_n = S_IDLE;
        end else if (tmr_zero) begin
          set_v = '1; ld = 1'b1; ld_val = WAIT_LOAD; st_n = S_EN_UNWIND;
        end
      S_EN_UNWIND:
        if (settled_v[SDQ_MST] || tmr_zero) begin clk_off = 1'b1; st_n = S_EN_FAILGATE; end
      S_EN_FAILGATE: begin rst_set = 1'b1; to_n = 1'b1; st_n = S_IDLE; end
      S_DIS_SWAIT:
        if (settled_v[SDQ_SLV]) begin
          set_v[SDQ_MST] = 1'b1; ld = 1'b1; ld_val = WAIT_LOAD; st_n = S_DIS_MWAIT;
        end else if (tmr_zero) begin
          clr_v[SDQ_SLV] = 1'b1; to_n = 1'b1; st_n = S_IDLE;
        end
      S_DIS_MWAIT:
        if (settled_v[SDQ_MST]) begin
          clk_off = 1'b1; st_n = S_DIS_GATE;
        end else if (tmr_zero) begin
          clr_v = '1; ld = 1'b1; ld_val = WAIT_LOAD; st_n = S_DIS_SREOPEN;
        end
      S_DIS_SREOPEN:
        if (settled_v[SDQ_SLV] || tmr_zero) begin to_n = 1'b1; st_n = S_IDLE; end
      S_DIS_GATE: begin rst_set = 1'b1; st_n = S_DIS_DONE; end
      S_DIS_DONE:
        if (is_rst_q) begin
          clk_on = 1'b1; ld = 1'b1; ld_val = PROP_LOAD; st_n = S_EN_PROP;
        end else begin
          done_n = 1'b1; st_n = S_IDLE;
        end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; is_rst_q <= 1'b0;
      clk_q <= 1'b0; urst_q <= 1'b0; done_q <= 1'b0; to_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      is_rst_q <= is_rst_n;
      if (clk_on)       clk_q <= 1'b1;
      else if (clk_off) clk_q <= 1'b0;
      if (rst_rel)      urst_q <= 1'b1;
      else if (rst_set) urst_q <= 1'b0;
      done_q <= done_n;
      to_q   <= to_n;
    end
  end

  assign busy         = (st_q != S_IDLE);
  assign op_done      = done_q;
  assign timed_out    = to_q;
  assign unit_clk_en  = clk_q;
  assign unit_rst_n   = urst_q;
  assign mst_stop_req = stop_v[SDQ_MST];
  assign slv_stop_req = stop_v[SDQ_SLV];
  assign id_word      = SDQ_ID_WORD;
endmodule

// File: rtl/sdq_seq_chk.sv
module sdq_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic op_done,
  input logic timed_out,
  input logic unit_clk_en,
  input logic unit_rst_n,
  input logic mst_stop_req,
  input logic slv_stop_req
);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && timed_out));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  assert_fail_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |=> !timed_out);
  assert_release_clk_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unit_rst_n) |-> !unit_clk_en);
  assert_assert_clk_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unit_rst_n) |-> !unit_clk_en);
  assert_slave_opens_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slv_stop_req) |-> !mst_stop_req);
  assert_master_stops_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_stop_req) |-> slv_stop_req);
  assert_open_needs_live_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_stop_req || !slv_stop_req) |-> (unit_clk_en && unit_rst_n));
endmodule

bind sdq_seq sdq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_done(op_done), .timed_out(timed_out),
  .unit_clk_en(unit_clk_en), .unit_rst_n(unit_rst_n),
  .mst_stop_req(mst_stop_req), .slv_stop_req(slv_stop_req)
);

// File: tb/tb_sdq_seq.sv
module tb_sdq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PROP   = 32;
  localparam int LIMIT  = 50;
  localparam logic [7:0] NEVER = 8'd255;

  // {op[22:21], mst delay[20:13], slv delay[12:5], exp timeout, clk, rst_n, mst stop, slv stop}
  localparam logic [22:0] VEC [12] = '{
    {2'd1, 8'd3,   8'd3,   5'b01100},
    {2'd2, 8'd3,   8'd3,   5'b00011},
    {2'd3, 8'd2,   8'd5,   5'b01100},
    {2'd2, 8'd3,   8'd255, 5'b11100},
    {2'd2, 8'd255, 8'd2,   5'b11100},
    {2'd2, 8'd2,   8'd2,   5'b00011},
    {2'd1, 8'd2,   8'd255, 5'b10011},
    {2'd1, 8'd255, 8'd2,   5'b10011},
    {2'd1, 8'd1,   8'd1,   5'b01100},
    {2'd3, 8'd4,   8'd4,   5'b01100},
    {2'd3, 8'd3,   8'd255, 5'b11100},
    {2'd2, 8'd2,   8'd2,   5'b00011}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic busy, op_done, timed_out, unit_clk_en, unit_rst_n;
  logic mst_stop_req, slv_stop_req, mst_ack, slv_ack;
  logic [31:0] id_word;
  logic [7:0] m_dly = 8'd2, s_dly = 8'd2;

  logic nb_valid = 0;
  logic [1:0] nb_op = 0;
  logic nb_ack = 0;
  logic nb_busy, nb_done, nb_to, nb_clk, nb_rst, nb_ms, nb_ss;
  logic [31:0] nb_id;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdq_seq #(.PROP_CYCLES(PROP), .ACK_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .op_done(op_done), .timed_out(timed_out),
    .unit_clk_en(unit_clk_en), .unit_rst_n(unit_rst_n),
    .mst_stop_req(mst_stop_req), .mst_ack(mst_ack),
    .slv_stop_req(slv_stop_req), .slv_ack(slv_ack), .id_word(id_word));

  sdq_seq #(.PROP_CYCLES(PROP), .ACK_LIMIT(LIMIT), .HAS_BRIDGE(1'b0)) dut_nb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(nb_valid), .cmd_op(nb_op),
    .busy(nb_busy), .op_done(nb_done), .timed_out(nb_to),
    .unit_clk_en(nb_clk), .unit_rst_n(nb_rst),
    .mst_stop_req(nb_ms), .mst_ack(nb_ack),
    .slv_stop_req(nb_ss), .slv_ack(nb_ack), .id_word(nb_id));

  // Bridge stubs: ack follows stop request after a programmable delay, or never.
  int m_cnt = 0, s_cnt = 0;
  logic m_ack_q, s_ack_q;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack_q <= 1'b1; s_ack_q <= 1'b1; m_cnt <= 0; s_cnt <= 0;
    end else begin
      if (mst_stop_req != m_ack_q && m_dly != NEVER) begin
        if (m_cnt >= int'(m_dly)) begin m_ack_q <= mst_stop_req; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else m_cnt <= 0;
      if (slv_stop_req != s_ack_q && s_dly != NEVER) begin
        if (s_cnt >= int'(s_dly)) begin s_ack_q <= slv_stop_req; s_cnt <= 0; end
        else s_cnt <= s_cnt + 1;
      end else s_cnt <= 0;
    end
  end
  assign mst_ack = m_ack_q;
  assign slv_ack = s_ack_q;

  // Order monitors sampled away from the active edge.
  int cyc = 0, t_mfall = 0, t_sfall = 0, t_mrise = 0, t_srise = 0, t_cfall = 0, t_rfall = 0;
  int run = 0, last_run = 0;
  logic clk_at_rel = 1'b1;
  logic pm = 1, ps = 1, pc = 0, pr = 0;
  always @(negedge clk) begin
    cyc++;
    if (pm && !mst_stop_req) t_mfall = cyc;
    if (!pm && mst_stop_req) t_mrise = cyc;
    if (ps && !slv_stop_req) t_sfall = cyc;
    if (!ps && slv_stop_req) t_srise = cyc;
    if (pc && !unit_clk_en) t_cfall = cyc;
    if (pr && !unit_rst_n) t_rfall = cyc;
    if (!pr && unit_rst_n) clk_at_rel = unit_clk_en;
    if (unit_clk_en && !unit_rst_n) run++;
    else begin if (run > 0) last_run = run; run = 0; end
    pm = mst_stop_req; ps = slv_stop_req; pc = unit_clk_en; pr = unit_rst_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, output logic got_to, output int cycles);
    @(negedge clk); cmd_valid = 1; cmd_op = op;
    @(negedge clk); cmd_valid = 0; cycles = 1;
    while (!(op_done || timed_out) && cycles < 3000) begin @(negedge clk); cycles++; end
    got_to = timed_out;
    if (cycles >= 3000) begin
      checks++; errors++;
      $display("FAIL R11 actual=no result pulse expected=result pulse");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic got_to;
    int cyc_n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {busy, op_done, timed_out, unit_clk_en, unit_rst_n, mst_stop_req, slv_stop_req},
        32'b0000011);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", {busy, unit_clk_en, unit_rst_n, mst_stop_req, slv_stop_req}, 32'b00011);
    chk("R12", id_word, 32'h62726467);
    chk("R12", nb_id, 32'h62726467);

    for (int i = 0; i < 12; i++) begin
      m_dly = VEC[i][20:13];
      s_dly = VEC[i][12:5];
      run_op(VEC[i][22:21], got_to, cyc_n);
      chk($sformatf("R5 R6 R7 R8 R9 outcome vec%0d", i), {31'b0, got_to}, {31'b0, VEC[i][4]});
      @(negedge clk);
      chk("R11", {op_done, timed_out}, 32'b00);
      repeat (12) @(negedge clk);
      chk($sformatf("R3 R4 R9 end state vec%0d", i),
          {unit_clk_en, unit_rst_n, mst_stop_req, slv_stop_req}, {28'b0, VEC[i][3:0]});
      if (i == 0) begin
        chk("R2 prop run", {31'b0, last_run >= PROP}, 32'd1);
        chk("R2 reset released with clock stopped", {31'b0, clk_at_rel}, 32'd0);
        chk("R3 master opens before slave", {31'b0, t_mfall < t_sfall}, 32'd1);
      end
      if (i == 1) begin
        chk("R4 slave stops before master", {31'b0, t_srise < t_mrise}, 32'd1);
        chk("R4 clock gated after master", {31'b0, t_mrise < t_cfall}, 32'd1);
        chk("R4 reset after clock gate", {31'b0, t_cfall < t_rfall}, 32'd1);
      end
      if (i == 3) chk("R5 wait bound", {31'b0, cyc_n >= LIMIT}, 32'd1);
    end

    // R11: command while busy is dropped
    m_dly = 8'd2; s_dly = 8'd2;
    @(negedge clk); cmd_valid = 1; cmd_op = 2'b01;
    @(negedge clk); cmd_valid = 0;
    repeat (3) @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b10;
    @(negedge clk); cmd_valid = 0;
    while (!(op_done || timed_out)) @(negedge clk);
    chk("R11 busy op outcome", {op_done, timed_out}, 32'b10);
    @(negedge clk);
    chk("R11 done single cycle", {31'b0, op_done}, 32'd0);
    repeat (40) @(negedge clk);
    chk("R11 busy command ignored", {busy, unit_clk_en, unit_rst_n, slv_stop_req}, 32'b0110);

    // R11: no-op code ignored
    @(negedge clk); cmd_valid = 1; cmd_op = 2'b00;
    @(negedge clk); cmd_valid = 0;
    repeat (3) @(negedge clk);
    chk("R11 no-op ignored", {busy, unit_clk_en, unit_rst_n, mst_stop_req}, 32'b0110);

    // R10: no bridges, acks ignored
    nb_ack = 1'b1;
    @(negedge clk); nb_valid = 1; nb_op = 2'b01;
    @(negedge clk); nb_valid = 0; nb_ack = 1'b0;
    while (!(nb_done || nb_to)) @(negedge clk);
    chk("R10 enable result", {nb_done, nb_to}, 32'b10);
    chk("R10 enable state", {nb_clk, nb_rst, nb_ms, nb_ss}, 32'b1111);
    @(negedge clk); nb_valid = 1; nb_op = 2'b10; nb_ack = 1'b1;
    @(negedge clk); nb_valid = 0;
    while (!(nb_done || nb_to)) @(negedge clk);
    chk("R10 disable result", {nb_done, nb_to}, 32'b10);
    @(negedge clk);
    chk("R10 disable state", {nb_clk, nb_rst, nb_ms, nb_ss}, 32'b0011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule